// File: doc/BRIEF.md
# Retransmit FIFO

This block is a single-clock first-in/first-out buffer for 9-bit words. Words go into a RAM array through a write pointer and come out through a separate read pointer. A registered occupancy count drives three status outputs, all active low: empty, full and more-than-half-full. The write strobe is refused while the buffer is full, and the read strobe is refused while it is empty. A refused strobe leaves its pointer where it was.

Read data is registered and comes with a one-cycle valid qualifier. While the qualifier is low, the data output keeps its last value.

In single-device mode, a rewind pulse moves the read pointer back to the first word written since reset. It leaves the write pointer alone. The occupancy then becomes the number of words written since reset, and all three flags follow from that count. This lets a frame be replayed, for example after a receiver reports an error, provided the frame never overran the array.

Top module: `rtx_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pointers, the occupancy, `rd_valid` and `rd_data` clear. After that edge `empty_n`=0, `full_n`=1 and `half_n`=1.
- R2: With `full_n`=1, `wr_en`=1 stores `wr_data` at the next consecutive location. With `full_n`=0, the write is ignored: no stored word is overwritten, and the word is never read back.
- R3: With `empty_n`=1, `rd_en`=1 reads the oldest unread word. With `empty_n`=0, the read is ignored, the read pointer stays put and `rd_valid` stays 0.
- R4: A write and a read that are both allowed in the same cycle both take effect. The occupancy is unchanged, and the word read is the oldest one stored before that cycle.
- R5: `empty_n` is 0 exactly when the occupancy is 0. `full_n` is 0 exactly when the occupancy equals DEPTH (16). Both never read 0 at once.
- R6: `half_n` is 0 exactly when the occupancy is above DEPTH/2. It falls on the write that moves the occupancy from 8 to 9, and it rises on the read that moves it back to 8.
- R7: `rd_valid` is 1 only in the cycle after an accepted read, with the word on `rd_data`. In every other cycle, `rd_data` holds its previous value.
- R8: A rewind is taken when `rewind`=1, `solo_mode`=1, `wr_en`=0, `rd_en`=0, and at most DEPTH writes have been accepted since reset. The next read then returns the first word written since reset, the occupancy becomes the number of writes since reset, and the write pointer does not move.
- R9: `rewind` has no effect when `solo_mode`=0, or when `wr_en` or `rd_en` is 1 in the same cycle.
- R10: Once more than DEPTH writes have been accepted since reset, `rewind` has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 9 | Word to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 9 | Registered read word |
| rd_valid | output | 1 | High the cycle after an accepted read |
| rewind | input | 1 | Retransmit request |
| solo_mode | input | 1 | Single-device mode; enables rewind |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| half_n | output | 1 | Low when more than half full |

## Verification
A write and a read can be accepted in the same edge. They can also meet at the flag boundaries: a write on an empty buffer, where only the write takes effect, and a read on a full buffer, where only the read takes effect.

The random stimulus raises both strobes together under write-heavy and read-heavy phases, so both edges of each flag are crossed while both strobes are active. Directed cycles pin the empty and full cases.

A bench queue model decides acceptance from the occupancy before the edge. It judges the result through the flags, `rd_valid` and the word order on the next read.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
  // index after idx in a ring of depth slots
  function automatic int next_slot(int idx, int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  // occupancy after one edge with the given accepted strobes
  function automatic int occ_step(int occ, bit wr_ok, bit rd_ok);
    return occ + int'(wr_ok) - int'(rd_ok);
  endfunction

  // more than half of the array in use
  function automatic bit over_half(int occ, int depth);
    return occ > depth / 2;
  endfunction
endpackage

// File: rtl/rtx_fifo_store.sv
module rtx_fifo_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rtx_fifo_ptrs.sv
module rtx_fifo_ptrs
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          rt_acc,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          replay_ok
);
  // writes since reset, saturating one past DEPTH
  logic [CW-1:0] wr_total;

  assign replay_ok = (wr_total <= CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      occ      <= '0;
      wr_total <= '0;
    end else begin
      if (wr_acc) begin
        wr_ptr <= AW'(next_slot(int'(wr_ptr), DEPTH));
        if (replay_ok) wr_total <= wr_total + 1'b1;
      end
      if (rt_acc) begin
        rd_ptr <= '0;
        occ    <= wr_total;
      end else begin
        if (rd_acc) rd_ptr <= AW'(next_slot(int'(rd_ptr), DEPTH));
        occ <= CW'(occ_step(int'(occ), wr_acc, rd_acc));
      end
    end
  end
endmodule

// File: rtl/rtx_fifo_status.sv
module rtx_fifo_status
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] occ,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  assign empty_n = (occ != '0);
  assign full_n  = (occ != CW'(DEPTH));
  assign half_n  = !over_half(int'(occ), DEPTH);
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rewind,
  input  logic              solo_mode,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  // named internal events, observed by the bound checker
  logic              wr_acc;
  logic              rd_acc;
  logic              rt_acc;
  logic              replay_ok;
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic [CW-1:0]     occ;
  logic [DATA_W-1:0] ram_q;

  assign wr_acc = wr_en && full_n;
  assign rd_acc = rd_en && empty_n;
  assign rt_acc = rewind && solo_mode && !wr_en && !rd_en && replay_ok;

  rtx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_acc),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (ram_q)
  );

  rtx_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_acc    (wr_acc),
    .rd_acc    (rd_acc),
    .rt_acc    (rt_acc),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .occ       (occ),
    .replay_ok (replay_ok)
  );

  rtx_fifo_status #(.DEPTH(DEPTH)) u_status (
    .occ     (occ),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) rd_data <= ram_q;
    end
  end
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              rewind,
  input logic              solo_mode,
  input logic              empty_n,
  input logic              full_n,
  input logic              half_n,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_acc,
  input logic              rd_acc,
  input logic              rt_acc,
  input logic [AW-1:0]     wr_ptr,
  input logic [AW-1:0]     rd_ptr
);
  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_en) |=> $stable(wr_ptr));

  assert_empty_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_en) |=> ($stable(rd_ptr) && !rd_valid));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));

  assert_half_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(half_n) |-> ($past(wr_acc) || $past(rt_acc)));

  assert_half_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_n) |-> ($past(rd_acc) || $past(rt_acc)));

  assert_valid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid);

  assert_data_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> (!rd_valid && $stable(rd_data)));

  assert_rewind_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rt_acc |=> (rd_ptr == '0 && $stable(wr_ptr)));

  assert_rewind_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && !solo_mode && !rd_en) |=> $stable(rd_ptr));
endmodule

bind rtx_fifo rtx_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_rtx_fifo.sv
module test_rtx_fifo;
  localparam int DW = 9;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic rewind = 1'b0;
  logic solo_mode = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_valid, empty_n, full_n, half_n;

  always #5 clk = ~clk;

  rtx_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_rtx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .rewind(rewind), .solo_mode(solo_mode),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model: every word written since reset, plus a read index
  int hist[$];
  int rd_idx = 0;
  int last_d = 0;

  function automatic int model_occ();
    return hist.size() - rd_idx;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; rewind = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(empty_n == 1'b0, "R1 empty_n", int'(empty_n), 0);
    chk(full_n == 1'b1, "R1 full_n", int'(full_n), 1);
    chk(half_n == 1'b1, "R1 half_n", int'(half_n), 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    hist.delete();
    rd_idx = 0;
    last_d = 0;
  endtask

  // one clock: drive at a falling edge, judge at the next falling edge
  task automatic step(bit w, int d, bit r, bit rt, bit md);
    int occ;
    bit wa, ra, ta;
    int exp_d;
    occ = model_occ();
    wa = w && occ < DEPTH;
    ra = r && occ > 0;
    ta = rt && md && !w && !r && hist.size() <= DEPTH;
    exp_d = ra ? hist[rd_idx] : last_d;
    wr_en = w; wr_data = DW'(d); rd_en = r; rewind = rt; solo_mode = md;
    @(posedge clk);
    @(negedge clk);
    if (ra) rd_idx++;
    if (wa) hist.push_back(d);
    if (ta) rd_idx = 0;
    wr_en = 0; rd_en = 0; rewind = 0;
    chk(rd_valid == ra, "R7 rd_valid", int'(rd_valid), int'(ra));
    chk(int'(rd_data) == exp_d, ra ? "R3 rd_data order" : "R7 rd_data held",
        int'(rd_data), exp_d);
    last_d = exp_d;
    occ = model_occ();
    chk(empty_n == (occ != 0), "R5 empty_n", int'(empty_n), int'(occ != 0));
    chk(full_n == (occ != DEPTH), "R5 full_n", int'(full_n), int'(occ != DEPTH));
    chk(half_n == !(occ > DEPTH / 2), "R6 half_n", int'(half_n), int'(!(occ > DEPTH / 2)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R2: fill to full, then a write while full must vanish
    for (int i = 0; i < DEPTH; i++) step(1, 16 + i, 0, 0, 1);
    chk(full_n == 1'b0, "R2 full after DEPTH writes", int'(full_n), 0);
    step(1, 9'h1AA, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 1, 0, 1);
      chk(int'(rd_data) == 16 + i, "R2 stored order", int'(rd_data), 16 + i);
    end
    chk(empty_n == 1'b0, "R2 refused word absent", int'(empty_n), 0);

    // R3: read while empty is ignored
    step(0, 0, 1, 0, 1);
    chk(rd_valid == 1'b0, "R3 read while empty", int'(rd_valid), 0);

    // R6: 8 words keep half_n high, the 9th pulls it low, one read restores it
    do_reset();
    for (int i = 0; i < 8; i++) step(1, 100 + i, 0, 0, 1);
    chk(half_n == 1'b1, "R6 at half", int'(half_n), 1);
    step(1, 108, 0, 0, 1);
    chk(half_n == 1'b0, "R6 above half", int'(half_n), 0);

    // R4: simultaneous write and read
    step(1, 200, 1, 0, 1);
    chk(int'(rd_data) == 100, "R4 oldest word", int'(rd_data), 100);
    chk(half_n == 1'b0, "R4 occupancy unchanged", int'(half_n), 0);
    step(0, 0, 1, 0, 1);
    chk(half_n == 1'b1, "R6 back to half", int'(half_n), 1);

    // R9: rewind refused without single-device mode or with a strobe
    step(0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 1);
    chk(int'(rd_data) == 102, "R9 mode low ignored", int'(rd_data), 102);
    step(0, 0, 1, 1, 1);
    chk(int'(rd_data) == 103, "R9 strobe high ignored", int'(rd_data), 103);

    // R8: rewind replays from the first word, write pointer intact
    step(0, 0, 0, 1, 1);
    chk(half_n == 1'b0, "R8 occupancy back to 10", int'(half_n), 0);
    step(0, 0, 1, 0, 1);
    chk(int'(rd_data) == 100, "R8 first word replayed", int'(rd_data), 100);
    step(1, 300, 0, 0, 1);
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 1);
    chk(int'(rd_data) == 300, "R8 write pointer kept", int'(rd_data), 300);

    // R10: after more than DEPTH writes, rewind is refused
    do_reset();
    for (int i = 0; i < DEPTH + 4; i++) begin
      step(1, 400 + i, 0, 0, 1);
      step(0, 0, 1, 0, 1);
    end
    step(1, 7, 0, 0, 1);
    step(0, 0, 0, 1, 1);
    chk(empty_n == 1'b1, "R10 rewind refused", int'(empty_n), 1);
    step(0, 0, 1, 0, 1);
    chk(int'(rd_data) == 7, "R10 order kept", int'(rd_data), 7);

    // constrained random with write-heavy and read-heavy phases
    for (int c = 0; c < 6000; c++) begin
      int wp;
      if (c % 400 == 0) do_reset();
      wp = ((c / 100) % 2 == 0) ? 70 : 30;
      step(($urandom % 100) < wp, int'($urandom % 512),
           ($urandom % 100) < (100 - wp), ($urandom % 30) == 0,
           ($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule